// File: doc/BRIEF.md
# Register Bit-Field Operation Unit

This unit carries out bit-field operations on a 32-bit register operand. A field is given by a starting offset and a length. The offset counts from the most significant bit toward the least significant bit. A field that runs past bit 0 wraps back around to bit 31. In one cycle the unit can test a field, force it to ones or zeros, complement it, insert into it, extract it with sign or zero extension, or search it for its first set bit.

The caller presents the operand, an insert source, the offset, the width code and an operation code, all with a valid strobe. One clock later the unit returns four things: the updated operand, a 32-bit result word for the extract and search operations, and the negative and zero flags for the field. When no strobe is present, the registered outputs keep their values.

Top module: `bf_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `rst_n` is low at a clock edge, all outputs are cleared to zero.
- R2: Field bit k, where k=0 is the field's most significant bit, sits at register bit 31 - ((offset + k) mod 32). A field therefore wraps from bit 0 around to bit 31.
- R3: A width code of 0 selects a 32-bit field. Codes 1 to 31 select that many bits.
- R4: For every operation except insert, `out_n` is the field's most significant bit and `out_z` is 1 when all field bits are zero. Both are taken from the operand before any change.
- R5: Operation 3 sets every field bit, operation 2 clears every field bit, and operation 1 complements every field bit.
- R6: Operation 7 writes the low width bits of `in_src` into the field, with the source's bit width-1 going to the field's most significant bit. N and Z are computed from that inserted value.
- R7: Operation 4 returns the field right-aligned and zero-extended in `out_res`. Operation 5 returns it sign-extended.
- R8: Operation 6 scans the field from its most significant bit. It returns offset + k for the first set bit at position k, or offset + width when the field has no set bit. The sum is not wrapped, so values up to 63 can appear.
- R9: Bits outside the field are never modified. Operations 0 (test), 4, 5 and 6 return the operand unchanged in `out_dst`.
- R10: `out_res` is zero after operations 0, 1, 2, 3 and 7.
- R11: After a cycle with `in_valid` low, `out_dst`, `out_res`, `out_n` and `out_z` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (0 test, 1 complement, 2 clear, 3 set, 4 unsigned extract, 5 signed extract, 6 find first one, 7 insert) |
| in_dst | input | 32 | Register operand holding the field |
| in_src | input | 32 | Insert source, value in its low bits |
| in_offset | input | 5 | Field start, counted from bit 31 |
| in_width | input | 5 | Field width code, 0 means 32 |
| out_valid | output | 1 | Result registered this cycle |
| out_dst | output | 32 | Updated operand |
| out_res | output | 32 | Extract or search result |
| out_n | output | 1 | Field most significant bit flag |
| out_z | output | 1 | Field all-zero flag |

## Verification
The hardest cases to reach from the ports are fields that wrap past bit 0 while being a full 32 bits wide or nearly so. In those cases the search result can reach offset plus 32, and the field's most significant bit sits at a low register bit. The stimulus table places fields at offsets 28 to 31 with width code 0 and with small widths, including an empty 32-bit search that must return 63. A swept loop then covers offsets and width codes across their full range for insert, signed extract and search, and compares each result with a bit-by-bit model of the numbering rule.

// File: rtl/bf_pkg.sv
// Shared types for the bit-field unit.
// Assumes: a 32-bit register operand; the operation codes below are fixed.
package bf_pkg;
    localparam int DATA_W = 32;
    localparam int POS_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        OP_TST  = 3'd0,
        OP_CHG  = 3'd1,
        OP_CLR  = 3'd2,
        OP_SET  = 3'd3,
        OP_EXTU = 3'd4,
        OP_EXTS = 3'd5,
        OP_FFO  = 3'd6,
        OP_INS  = 3'd7
    } bf_op_e;
endpackage

// File: rtl/bf_rotate.sv
// Barrel rotator. ROT_LEFT picks the direction at elaboration.
// Assumes: W is a power of two and the amount is below W.
module bf_rotate #(
    parameter int W        = 32,
    parameter bit ROT_LEFT = 1'b1,
    localparam int AW      = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] doubled;

    generate
        if (ROT_LEFT) begin : g_left
            // Rotate left: shift a doubled copy and keep the upper half.
            always_comb doubled = {din, din} << amt;
            assign dout = doubled[2*W-1:W];
        end else begin : g_right
            // Rotate right: shift a doubled copy and keep the lower half.
            always_comb doubled = {din, din} >> amt;
            assign dout = doubled[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/bf_mask.sv
// Builds the two field masks for a length of 1..W bits.
// Assumes: len is never zero (the caller has mapped code 0 to W).
module bf_mask #(
    parameter int W  = 32,
    localparam int LW = $clog2(W) + 1
) (
    input  logic [LW-1:0] len,
    output logic [W-1:0]  top_mask,
    output logic [W-1:0]  low_mask
);
    // Set len bits at the top and len bits at the bottom.
    always_comb begin
        top_mask = ~({W{1'b1}} >> len);
        low_mask = ~({W{1'b1}} << len);
    end
endmodule

// File: rtl/bf_ffo.sv
// MSB-first search of a field that is aligned to the top of the word.
// Assumes: the field's MSB is at bit W-1 and len is 1..W.
module bf_ffo #(
    parameter int W  = 32,
    localparam int LW = $clog2(W) + 1
) (
    input  logic [W-1:0]  aligned,
    input  logic [LW-1:0] len,
    output logic          hit,
    output logic [LW-1:0] idx
);
    // Walk from the far end so that the lowest in-field index is kept.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (aligned[W-1-i] && (LW'(i) < len)) begin
                hit = 1'b1;
                idx = LW'(i);
            end
        end
    end
endmodule

// File: rtl/bf_unit.sv
// Bit-field operation unit: test, set, clear, complement, insert,
// extract (signed or unsigned) and find-first-one on a 32-bit operand.
// The operand is rotated so that the field starts at the MSB, the work is
// done in that frame, and the result is rotated back.
// Assumes: results are registered one cycle after in_valid, and the
// outputs hold while in_valid is low.
module bf_unit
    import bf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          in_op,
    input  logic [DATA_W-1:0]   in_dst,
    input  logic [DATA_W-1:0]   in_src,
    input  logic [POS_W-1:0]    in_offset,
    input  logic [POS_W-1:0]    in_width,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_dst,
    output logic [DATA_W-1:0]   out_res,
    output logic                out_n,
    output logic                out_z
);
    localparam int LW = POS_W + 1;

    bf_op_e            op;
    logic [LW-1:0]     len;
    logic [LW-1:0]     shamt;
    logic [DATA_W-1:0] rot;
    logic [DATA_W-1:0] top_mask;
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] reg_mask;
    logic [DATA_W-1:0] fld;
    logic [DATA_W-1:0] ins_val;
    logic [DATA_W-1:0] ins_rot;
    logic [DATA_W-1:0] new_rot;
    logic [DATA_W-1:0] new_dst;
    logic [DATA_W-1:0] res_d;
    logic              n_d;
    logic              z_d;
    logic              ffo_hit;
    logic [LW-1:0]     ffo_idx;

    // Decode the op code and map width code 0 to a full-width field.
    always_comb begin
        op    = bf_op_e'(in_op);
        len   = (in_width == '0) ? LW'(DATA_W) : {1'b0, in_width};
        shamt = LW'(DATA_W) - len;
    end

    bf_rotate #(.W(DATA_W), .ROT_LEFT(1'b1)) u_rot_in (
        .din (in_dst), .amt (in_offset), .dout (rot)
    );

    bf_mask #(.W(DATA_W)) u_mask (
        .len (len), .top_mask (top_mask), .low_mask (low_mask)
    );

    bf_rotate #(.W(DATA_W), .ROT_LEFT(1'b0)) u_rot_mask (
        .din (top_mask), .amt (in_offset), .dout (reg_mask)
    );

    bf_ffo #(.W(DATA_W)) u_ffo (
        .aligned (rot), .len (len), .hit (ffo_hit), .idx (ffo_idx)
    );

    // Right-align the field and the insert value, and form the flags.
    always_comb begin
        fld     = rot >> shamt;
        ins_val = in_src & low_mask;
        ins_rot = ins_val << shamt;
        if (op == OP_INS) begin
            n_d = ins_rot[DATA_W-1];
            z_d = (ins_val == '0);
        end else begin
            n_d = rot[DATA_W-1];
            z_d = (fld == '0);
        end
    end

    // Apply the modifying operation in the rotated frame.
    always_comb begin
        unique case (op)
            OP_SET:  new_rot = rot | top_mask;
            OP_CLR:  new_rot = rot & ~top_mask;
            OP_CHG:  new_rot = rot ^ top_mask;
            OP_INS:  new_rot = (rot & ~top_mask) | (ins_rot & top_mask);
            default: new_rot = rot;
        endcase
    end

    bf_rotate #(.W(DATA_W), .ROT_LEFT(1'b0)) u_rot_out (
        .din (new_rot), .amt (in_offset), .dout (new_dst)
    );

    // Select the result word for extract and search operations.
    always_comb begin
        unique case (op)
            OP_EXTU: res_d = fld;
            OP_EXTS: res_d = fld | (n_d ? ~low_mask : '0);
            OP_FFO:  res_d = DATA_W'(in_offset) + DATA_W'(ffo_hit ? ffo_idx : len);
            default: res_d = '0;
        endcase
    end

    // Output register: cleared by reset, loaded on a valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dst   <= '0;
            out_res   <= '0;
            out_n     <= 1'b0;
            out_z     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_dst <= new_dst;
                out_res <= res_d;
                out_n   <= n_d;
                out_z   <= z_d;
            end
        end
    end

    // R1: a strobe gives a valid result on the next cycle only.
    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11: outputs hold when no strobe was given.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_dst) && $stable(out_res) &&
                       $stable(out_n) && $stable(out_z)));

    // R9: only bits under the field mask may differ from the operand.
    a_r9_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((out_dst ^ $past(in_dst)) & ~$past(reg_mask)) == '0));

    // R5: a set leaves every field bit at one.
    a_r5_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SET) |=> ((out_dst & $past(reg_mask)) == $past(reg_mask)));

    // R10: modifying operations and test report a zero result word.
    a_r10_res_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_TST || op == OP_SET || op == OP_CLR ||
                      op == OP_CHG || op == OP_INS)) |=> (out_res == '0));

    // R7: a signed extract's top bit matches the N flag.
    a_r7_sign_matches_n: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_EXTS) |=> (out_res[DATA_W-1] == out_n));

    // R8: a search never reports beyond offset plus width.
    a_r8_ffo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_FFO) |=>
            (out_res <= DATA_W'($past(in_offset)) + DATA_W'($past(len))));
endmodule

// File: tb/bf_unit_tb_top.sv
// Self-checking bench for bf_unit: a hand-computed vector table, then
// directed reset, latency, hold and swept wrap-around checks.
module bf_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [31:0] in_dst = '0;
    logic [31:0] in_src = '0;
    logic [4:0]  in_offset = '0;
    logic [4:0]  in_width = '0;
    logic        out_valid;
    logic [31:0] out_dst;
    logic [31:0] out_res;
    logic        out_n;
    logic        out_z;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bf_unit dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
        .in_dst (in_dst), .in_src (in_src), .in_offset (in_offset),
        .in_width (in_width), .out_valid (out_valid), .out_dst (out_dst),
        .out_res (out_res), .out_n (out_n), .out_z (out_z)
    );

    // Vector: op, offset, width code, dst, src, exp dst, exp res, exp N, exp Z.
    localparam int NV = 17;
    localparam logic [142:0] VEC [NV] = '{
        {3'd0, 5'd0,  5'd8,  32'h80000000, 32'h0, 32'h80000000, 32'h0,        1'b1, 1'b0},
        {3'd3, 5'd4,  5'd8,  32'h00000000, 32'h0, 32'h0FF00000, 32'h0,        1'b0, 1'b1},
        {3'd2, 5'd0,  5'd0,  32'hFFFFFFFF, 32'h0, 32'h00000000, 32'h0,        1'b1, 1'b0},
        {3'd1, 5'd28, 5'd8,  32'h00000000, 32'h0, 32'hF000000F, 32'h0,        1'b0, 1'b1},
        {3'd4, 5'd8,  5'd12, 32'h00ABC000, 32'h0, 32'h00ABC000, 32'h00000ABC, 1'b1, 1'b0},
        {3'd5, 5'd8,  5'd12, 32'h00ABC000, 32'h0, 32'h00ABC000, 32'hFFFFFABC, 1'b1, 1'b0},
        {3'd5, 5'd8,  5'd12, 32'h005BC000, 32'h0, 32'h005BC000, 32'h000005BC, 1'b0, 1'b0},
        {3'd6, 5'd4,  5'd8,  32'h00400000, 32'h0, 32'h00400000, 32'd9,        1'b0, 1'b0},
        {3'd6, 5'd4,  5'd8,  32'hF00FFFFF, 32'h0, 32'hF00FFFFF, 32'd12,       1'b0, 1'b1},
        {3'd7, 5'd16, 5'd4,  32'hFFFFFFFF, 32'h5, 32'hFFFF5FFF, 32'h0,        1'b0, 1'b0},
        {3'd7, 5'd0,  5'd0,  32'h12345678, 32'h80000000, 32'h80000000, 32'h0, 1'b1, 1'b0},
        {3'd6, 5'd31, 5'd0,  32'h00000001, 32'h0, 32'h00000001, 32'd31,       1'b1, 1'b0},
        {3'd6, 5'd31, 5'd0,  32'h00000000, 32'h0, 32'h00000000, 32'd63,       1'b0, 1'b1},
        {3'd7, 5'd30, 5'd4,  32'h00000000, 32'hF, 32'hC0000003, 32'h0,        1'b1, 1'b0},
        {3'd4, 5'd30, 5'd4,  32'h80000002, 32'h0, 32'h80000002, 32'h0000000A, 1'b1, 1'b0},
        {3'd0, 5'd3,  5'd1,  32'h10000000, 32'h0, 32'h10000000, 32'h0,        1'b1, 1'b0},
        {3'd1, 5'd0,  5'd16, 32'h12345678, 32'h0, 32'hEDCB5678, 32'h0,        1'b0, 1'b0}
    };
    localparam string VTAG [NV] = '{
        "R4", "R5", "R3", "R2", "R7", "R7", "R7", "R8", "R8",
        "R6", "R6", "R8", "R8", "R2", "R2", "R4", "R5"
    };

    // One compare; prints a FAIL line on mismatch.
    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge; sample one cycle later.
    task automatic apply(input logic [2:0] op, input logic [4:0] off,
                         input logic [4:0] wc, input logic [31:0] dst,
                         input logic [31:0] src);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_offset = off; in_width = wc;
        in_dst = dst; in_src = src;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Bit-by-bit model built from the numbering rule of R2.
    task automatic model(input logic [2:0] op, input logic [4:0] off,
                         input logic [4:0] wc, input logic [31:0] dst,
                         input logic [31:0] src, output logic [31:0] ndst,
                         output logic [31:0] res, output logic n,
                         output logic z);
        int w;
        int first;
        logic [31:0] val;
        w = (wc == 0) ? 32 : int'(wc);
        ndst = dst; val = '0; first = -1;
        for (int k = 0; k < w; k++) begin
            int p;
            logic b;
            p = 31 - ((int'(off) + k) % 32);
            b = (op == 3'd7) ? src[w-1-k] : dst[p];
            val = {val[30:0], b};
            if (b && first < 0) first = k;
            if (op == 3'd7) ndst[p] = src[w-1-k];
            if (op == 3'd3) ndst[p] = 1'b1;
            if (op == 3'd2) ndst[p] = 1'b0;
            if (op == 3'd1) ndst[p] = ~dst[p];
        end
        n = val[w-1];
        z = (val == 0);
        case (op)
            3'd4: res = val;
            3'd5: res = (n && w < 32) ? (val | (32'hFFFFFFFF << w)) : val;
            3'd6: res = 32'(int'(off) + ((first < 0) ? w : first));
            default: res = '0;
        endcase
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] e_dst, e_res;
        logic        e_n, e_z;

        // R1: reset clears all outputs even with a strobe present.
        in_valid = 1'b1; in_op = 3'd3; in_dst = 32'hDEADBEEF;
        repeat (3) @(negedge clk);
        check("R1", "reset valid", {31'b0, out_valid}, 32'h0);
        check("R1", "reset dst", out_dst, 32'h0);
        check("R1", "reset res", out_res, 32'h0);
        check("R1", "reset flags", {30'b0, out_n, out_z}, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            logic [142:0] v;
            v = VEC[i];
            apply(v[142:140], v[139:135], v[134:130], v[129:98], v[97:66]);
            check(VTAG[i], "table dst", out_dst, v[65:34]);
            check(VTAG[i], "table res", out_res, v[33:2]);
            check(VTAG[i], "table N", {31'b0, out_n}, {31'b0, v[1]});
            check(VTAG[i], "table Z", {31'b0, out_z}, {31'b0, v[0]});
        end

        // R1: the valid pulse lasts one cycle; R11: outputs then hold.
        apply(3'd5, 5'd8, 5'd12, 32'h00ABC000, 32'h0);
        check("R1", "valid after strobe", {31'b0, out_valid}, 32'h1);
        in_dst = 32'h0; in_op = 3'd3; in_width = 5'd0;
        @(negedge clk);
        check("R1", "valid drops", {31'b0, out_valid}, 32'h0);
        repeat (2) @(negedge clk);
        check("R11", "hold res", out_res, 32'hFFFFFABC);
        check("R11", "hold dst", out_dst, 32'h00ABC000);
        check("R11", "hold N", {31'b0, out_n}, 32'h1);

        // R9 and R10: a test returns the operand and a zero result.
        apply(3'd0, 5'd20, 5'd9, 32'hA5A5A5A5, 32'hFFFFFFFF);
        check("R9", "test keeps dst", out_dst, 32'hA5A5A5A5);
        check("R10", "test res zero", out_res, 32'h0);

        // R2 R3 R6 R7 R8 R9: sweep offsets and width codes against the model.
        for (int off = 0; off < 32; off += 3) begin
            for (int wc = 0; wc < 32; wc += 5) begin
                for (int o = 0; o < 8; o++) begin
                    logic [31:0] d, s;
                    d = 32'h9E3779B9 ^ (32'(off) << 11) ^ 32'(wc * 7 + o);
                    s = ~d ^ 32'(off);
                    if (o == 6 && wc > 10) d = 32'h0;
                    model(3'(o), 5'(off), 5'(wc), d, s, e_dst, e_res, e_n, e_z);
                    apply(3'(o), 5'(off), 5'(wc), d, s);
                    check("R2", "sweep dst", out_dst, e_dst);
                    check("R8", "sweep res", out_res, e_res);
                    check("R4", "sweep flags", {30'b0, out_n, out_z},
                          {30'b0, e_n, e_z});
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule